// File: doc/BRIEF.md
# Page Access Permission Checker

This block sits next to an address translation lookup. For every memory access it decides whether the access may go ahead or must raise a page fault. Each request carries the kind of access (instruction fetch, data read or data write), the privilege of the code making it (supervisor or user), and the attributes of the matching translation entry: present, user-accessible, writable and no-execute. A control word and a few enable inputs select which protections apply: no-execute enforcement, write protection for supervisor code, blocking supervisor fetches from user pages, and blocking supervisor data access to user pages. An override input lifts only the supervisor data-access block, for code that must copy to or from user buffers on purpose.

The verdict is computed combinationally from the inputs in the cycle the translation result arrives. It is registered once, so the response appears on the cycle after the request. The response holds a fault flag and an 8-bit cause word. The low nibble of the cause word reports the access itself. The high nibble gives a code for the single protection that was violated, picked by a fixed priority when several apply at once.

Top module: `pgperm_check`

## Requirements
- R1: Reset (rst_n low) clears rsp_valid and rsp_fault. A request sampled with req_valid high at a rising edge produces rsp_valid high after that edge, and only then.
- R2: An access to a page whose present attribute is 0 faults with violation code 1.
- R3: A user-mode access (req_user=1) to a page with pte_user=0 faults with violation code 2, whatever the access kind.
- R4: When bit 21 of ctl_word is set, a supervisor data read or write to a user page faults with code 3. It does not fault when sa_override is 1.
- R5: When bit 20 of ctl_word is set, a supervisor fetch from a user page faults with code 4. sa_override has no effect on this check.
- R6: A fetch from a page with pte_nx=1 faults with code 5 only when nx_en is 1. When nx_en is 0 the attribute is ignored.
- R7: A write to a page with pte_writable=0 faults with code 6. In user mode it always faults. In supervisor mode it faults only when wp_en is 1.
- R8: When several violations apply, the reported code is the one that comes first in the order not-present, user privilege, supervisor data, supervisor fetch, no-execute, write-protect.
- R9: The access kind is encoded as 00 fetch, 01 read, 10 write, and 11 is treated as a read. Cause bit 0 holds the present attribute, bit 1 is set for a write, bit 2 for user mode and bit 3 for a fetch. Bits 7:4 hold the violation code, which is 0 when the access is allowed. rsp_fault is set exactly when the code is non-zero.
- R10: While no response is valid, rsp_fault is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request present this cycle |
| req_kind | input | 2 | Access kind: 00 fetch, 01 read, 10 write, 11 read |
| req_user | input | 1 | 1 for user mode, 0 for supervisor mode |
| pte_present | input | 1 | Translation entry present attribute |
| pte_user | input | 1 | Page is accessible from user mode |
| pte_writable | input | 1 | Page is writable |
| pte_nx | input | 1 | Page is marked no-execute |
| ctl_word | input | 32 | Control word: bit 20 blocks supervisor fetch from user pages, bit 21 blocks supervisor data access to user pages |
| nx_en | input | 1 | Global no-execute enforcement enable |
| wp_en | input | 1 | Supervisor write-protect enable |
| sa_override | input | 1 | Temporarily permits supervisor data access to user pages |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_fault | output | 1 | Access must raise a page fault |
| rsp_cause | output | 8 | Cause word: bit0 present, bit1 write, bit2 user, bit3 fetch, bits 7:4 violation code |

## Verification
The hardest case is several protections violated by one access, so that only the priority decides the reported code. A typical example is a supervisor write to a read-only user page while the data-access block and write protection are both on. The stimulus reaches every such overlap by sweeping all combinations of access kind, privilege, the four page attributes and the five control inputs. The bits of the control word other than 20 and 21 are held at a busy pattern throughout, so that a decode from the wrong bit position shows up. Directed requests then single out the override cases, the disabled-enable cases and the reserved access kind.

// File: rtl/pgperm_pkg.sv
package pgperm_pkg;

    localparam int CODE_W   = 4;
    localparam int NUM_VIOL = 6;
    localparam int CAUSE_W  = CODE_W + 4;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'b00,
        ACC_READ  = 2'b01,
        ACC_WRITE = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_kind_e;

    // Code value equals priority rank plus one: lower code wins
    typedef enum logic [CODE_W-1:0] {
        VC_NONE        = 4'd0,
        VC_NOT_PRESENT = 4'd1,
        VC_USER_PRIV   = 4'd2,
        VC_SUP_DATA    = 4'd3,
        VC_SUP_EXEC    = 4'd4,
        VC_NO_EXEC     = 4'd5,
        VC_WRITE_PROT  = 4'd6
    } viol_code_e;

    // Index into the violation vector, index 0 is highest priority
    localparam int IDX_NP    = 0;
    localparam int IDX_UPRIV = 1;
    localparam int IDX_SDATA = 2;
    localparam int IDX_SEXEC = 3;
    localparam int IDX_NX    = 4;
    localparam int IDX_WPROT = 5;

endpackage

// File: rtl/pgperm_rules.sv
module pgperm_rules
    import pgperm_pkg::*;
(
    input  logic [1:0]          kind,
    input  logic                user_mode,
    input  logic                pg_present,
    input  logic                pg_user,
    input  logic                pg_writable,
    input  logic                pg_nx,
    input  logic                nx_on,
    input  logic                wp_on,
    input  logic                sexec_on,
    input  logic                sdata_on,
    input  logic                sdata_ovr,
    output logic [NUM_VIOL-1:0] viol
);

    logic is_fetch;
    logic is_write;
    logic sup_on_user_pg;

    always_comb begin
        is_fetch       = (kind == ACC_FETCH);
        is_write       = (kind == ACC_WRITE);
        sup_on_user_pg = !user_mode && pg_user;

        viol            = '0;
        viol[IDX_NP]    = !pg_present;
        viol[IDX_UPRIV] = user_mode && !pg_user;
        viol[IDX_SDATA] = sup_on_user_pg && !is_fetch && sdata_on && !sdata_ovr;
        viol[IDX_SEXEC] = sup_on_user_pg && is_fetch && sexec_on;
        viol[IDX_NX]    = is_fetch && nx_on && pg_nx;
        viol[IDX_WPROT] = is_write && !pg_writable && (user_mode || wp_on);
    end

endmodule

// File: rtl/pgperm_prio.sv
module pgperm_prio
    import pgperm_pkg::*;
#(
    parameter int N = NUM_VIOL
) (
    input  logic [N-1:0]      req,
    output logic [CODE_W-1:0] code
);

    always_comb begin
        code = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                code = CODE_W'(i + 1);
            end
        end
    end

endmodule

// File: rtl/pgperm_check.sv
module pgperm_check
    import pgperm_pkg::*;
#(
    parameter int CTL_W   = 32,
    parameter int SEXEC_B = 20,
    parameter int SDATA_B = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_kind,
    input  logic             req_user,
    input  logic             pte_present,
    input  logic             pte_user,
    input  logic             pte_writable,
    input  logic             pte_nx,
    input  logic [CTL_W-1:0] ctl_word,
    input  logic             nx_en,
    input  logic             wp_en,
    input  logic             sa_override,
    output logic             rsp_valid,
    output logic             rsp_fault,
    output logic [7:0]       rsp_cause
);

    logic [NUM_VIOL-1:0] viol;
    logic [CODE_W-1:0]   code;
    logic [CAUSE_W-1:0]  cause_nxt;

    pgperm_rules u_rules (
        .kind        (req_kind),
        .user_mode   (req_user),
        .pg_present  (pte_present),
        .pg_user     (pte_user),
        .pg_writable (pte_writable),
        .pg_nx       (pte_nx),
        .nx_on       (nx_en),
        .wp_on       (wp_en),
        .sexec_on    (ctl_word[SEXEC_B]),
        .sdata_on    (ctl_word[SDATA_B]),
        .sdata_ovr   (sa_override),
        .viol        (viol)
    );

    pgperm_prio #(.N(NUM_VIOL)) u_prio (
        .req  (viol),
        .code (code)
    );

    always_comb begin
        cause_nxt = {code,
                     req_kind == ACC_FETCH,
                     req_user,
                     req_kind == ACC_WRITE,
                     pte_present};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_cause <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_fault <= req_valid && (code != VC_NONE);
            rsp_cause <= req_valid ? cause_nxt : '0;
        end
    end

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R1
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R1
    AST_NOT_PRESENT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !pte_present) |=> (rsp_cause[7:4] == VC_NOT_PRESENT)); // R2
    AST_USER_PRIV_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && pte_present && req_user && !pte_user) |=> (rsp_cause[7:4] == VC_USER_PRIV)); // R3
    AST_SEXEC_NO_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == ACC_FETCH && !req_user && pte_user && ctl_word[SEXEC_B]) |=> rsp_fault); // R5
    AST_NX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !nx_en) |=> (rsp_cause[7:4] != VC_NO_EXEC)); // R6
    AST_SUP_WP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_user && !wp_en) |=> (rsp_cause[7:4] != VC_WRITE_PROT)); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !rsp_fault); // R10

endmodule

// File: tb/sim_pgperm_check.sv
`timescale 1ns/1ps
module sim_pgperm_check;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'b00;
    logic        req_user = 1'b0;
    logic        pte_present = 1'b0;
    logic        pte_user = 1'b0;
    logic        pte_writable = 1'b0;
    logic        pte_nx = 1'b0;
    logic [31:0] ctl_word = 32'h0;
    logic        nx_en = 1'b0;
    logic        wp_en = 1'b0;
    logic        sa_override = 1'b0;
    logic        rsp_valid;
    logic        rsp_fault;
    logic [7:0]  rsp_cause;

    localparam logic [31:0] BUSY_PAT = 32'hA5CF_0F3C & ~32'h0030_0000;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [8:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    pgperm_check u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_user(req_user), .pte_present(pte_present), .pte_user(pte_user),
        .pte_writable(pte_writable), .pte_nx(pte_nx), .ctl_word(ctl_word),
        .nx_en(nx_en), .wp_en(wp_en), .sa_override(sa_override),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause)
    );

    // Model built from the requirement text, returns {fault, cause}
    function automatic logic [8:0] model(input logic [1:0] k, input logic u,
        input logic pp, input logic pu, input logic pw, input logic px,
        input logic nxe, input logic wp, input logic sx, input logic sd, input logic ov);
        logic [3:0] c;
        logic f, w, d;
        f = (k == 2'b00);
        w = (k == 2'b10);
        d = !f;
        if (!pp)                                  c = 4'd1; // R2
        else if (u && !pu)                        c = 4'd2; // R3
        else if (!u && pu && d && sd && !ov)      c = 4'd3; // R4
        else if (!u && pu && f && sx)             c = 4'd4; // R5
        else if (f && nxe && px)                  c = 4'd5; // R6
        else if (w && !pw && (u || wp))           c = 4'd6; // R7
        else                                      c = 4'd0;
        return {c != 4'd0, c, f, u, w, pp};
    endfunction

    function automatic string tag_of(input logic [8:0] e);
        case (e[7:4])
            4'd1: return "R2";
            4'd2: return "R3";
            4'd3: return "R4";
            4'd4: return "R5";
            4'd5: return "R6";
            4'd6: return "R7";
            default: return "R9";
        endcase
    endfunction

    task automatic drive(input logic [1:0] k, input logic u, input logic pp,
        input logic pu, input logic pw, input logic px, input logic nxe,
        input logic wp, input logic sx, input logic sd, input logic ov, input string tag);
        logic [8:0] e;
        @(negedge clk);
        req_valid    = 1'b1;
        req_kind     = k;
        req_user     = u;
        pte_present  = pp;
        pte_user     = pu;
        pte_writable = pw;
        pte_nx       = px;
        nx_en        = nxe;
        wp_en        = wp;
        sa_override  = ov;
        ctl_word     = BUSY_PAT | {10'b0, sd, sx, 20'b0};
        e = model(k, u, pp, pu, pw, px, nxe, wp, sx, sd, ov);
        exp_q.push_back(e);
        tag_q.push_back(tag == "" ? tag_of(e) : tag);
    endtask

    // Monitor: one response per pushed request
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL R1 unexpected response cause=%h expected none", rsp_cause);
            end else begin
                logic [8:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if ({rsp_fault, rsp_cause} !== e) begin
                    bad++;
                    $display("FAIL %s got fault=%b cause=%h expected fault=%b cause=%h",
                             t, rsp_fault, rsp_cause, e[8], e[7:0]);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        total++;
        if (rsp_valid !== 1'b0 || rsp_fault !== 1'b0) begin
            bad++;
            $display("FAIL R1 reset state valid=%b fault=%b expected 0 0", rsp_valid, rsp_fault);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // Directed cases
        drive(2'b01, 0, 1, 1, 1, 0, 0, 0, 0, 1, 1, "R4");  // override lifts data block
        drive(2'b10, 0, 1, 1, 1, 0, 0, 0, 0, 1, 0, "R4");  // data block active
        drive(2'b00, 0, 1, 1, 1, 0, 0, 0, 1, 1, 1, "R5");  // override ignored for fetch
        drive(2'b00, 0, 1, 1, 1, 1, 0, 0, 0, 0, 0, "R6");  // nx ignored when disabled
        drive(2'b00, 1, 1, 1, 1, 1, 1, 0, 0, 0, 0, "R6");  // nx enforced
        drive(2'b10, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R7");  // supervisor write, wp off
        drive(2'b10, 0, 1, 0, 0, 0, 0, 1, 0, 0, 0, "R7");  // supervisor write, wp on
        drive(2'b10, 1, 1, 1, 0, 0, 0, 0, 0, 0, 0, "R7");  // user write always checked
        drive(2'b10, 0, 1, 1, 0, 0, 0, 1, 0, 1, 0, "R8");  // data block beats write protect
        drive(2'b00, 1, 1, 0, 1, 1, 1, 0, 1, 0, 0, "R8");  // privilege beats nx
        drive(2'b00, 1, 0, 0, 1, 1, 1, 0, 1, 0, 0, "R8");  // not present beats all
        drive(2'b11, 1, 1, 1, 0, 1, 1, 1, 0, 0, 0, "R9");  // reserved kind as read
        drive(2'b11, 0, 1, 1, 1, 0, 0, 0, 0, 1, 0, "R9");  // reserved kind hits data block

        // Exhaustive sweep
        for (int i = 0; i < 3 * 1024; i++) begin
            logic [9:0] b;
            b = 10'(i / 3);
            drive(2'(i % 3), b[0], b[1], b[2], b[3], b[4], b[5], b[6], b[7], b[8], b[9], "");
        end

        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        total++;
        if (rsp_valid !== 1'b0 || rsp_fault !== 1'b0) begin
            bad++;
            $display("FAIL R10 idle valid=%b fault=%b expected 0 0", rsp_valid, rsp_fault);
        end
        total++;
        if (exp_q.size() != 0) begin
            bad++;
            $display("FAIL R1 missing responses got %0d left expected 0", exp_q.size());
        end
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule